// File: doc/BRIEF.md
# TDM Frame Serializer

This block is the transmit side of a serial audio port that runs as bus master. It is clocked by the bit clock. It generates the frame sync and shifts parallel samples out one bit per bit clock. Each frame holds one to eight slots. Each slot is a run of bit clocks that can carry one sample in a fixed-size container. Two framing styles are offered. The first is a word-select level that marks the two halves of the frame. The second is a short pulse at the start of each frame.

A producer supplies one sample word per enabled slot over a valid/ready handshake. All framing choices come from static configuration inputs: slot length, slot count, container size, padding, data delay, pulse width, bit order, drive edge, slot enable mask and output-enable policy. These inputs are changed only while reset is held. When a sample is not ready at the start of an enabled slot, the slot carries zeros and a sticky flag records the miss.

Top module: `tdm_frame_serializer`

## Requirements
- R1: A slot lasts `cfg_slot_len_m1`+1 bit clocks and a frame lasts `cfg_slots_m1`+1 slots; frames repeat without gaps. The outputs for frame position k after reset is released appear after rising edge k+1, where position 0 is the first bit clock of slot 0.
- R2: With `cfg_pulse_mode`=0, `frame_sync` is a level. It is low in slots with index below ceil(slots/2) and high in the others when `cfg_ws_invert`=0, and it is the inverse of that when `cfg_ws_invert`=1.
- R3: With `cfg_pulse_mode`=1, `frame_sync` is high for the first `cfg_pulse_len_m1`+1 bit clocks of each frame, or for the whole frame if that count is longer than the frame, and low otherwise.
- R4: `s_ready` is high exactly in the bit clock that starts a slot whose bit in `cfg_slot_mask` is set (bit i belongs to slot i). A sample is taken when `s_valid` is also high. Disabled slots take no sample.
- R5: The container holds 4·code+4 bits for `cfg_size_code` 1..7, and 8 bits for code 0. The low container-minus-`cfg_pad_bits` bits of `s_data` are sent, the remaining container positions are sent as 0, and bit clocks outside any enabled container send 0.
- R6: The first container bit is sent in slot bit clock `cfg_data_delay`. Container bits that would fall past the end of the slot are dropped.
- R7: `cfg_lsb_first`=0 sends the valid bits MSB first, and 1 sends them LSB first.
- R8: `cfg_fall_drive`=0 changes `sdata`, `frame_sync` and `sdata_oe` on the rising edge. With 1 they change on the falling edge, half a bit clock later.
- R9: `cfg_hiz_mode` controls `sdata_oe`. Code 1 drives only during container bits of enabled slots. Code 2 does the same and holds the drive for half a bit clock after each such run. Codes 0 and 3 drive always.
- R10: A start of an enabled slot without `s_valid` sends zeros for that slot and sets `underflow` one clock later. `underflow` stays set until `uf_clear` is sampled high, and a new miss in the same clock wins over the clear.
- R11: While `rst_n` is low, `frame_sync`, `sdata` and `underflow` are 0, and `sdata_oe` is 1 only for hi-Z codes 0 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pulse_mode | input | 1 | 0 word-select level, 1 frame pulse |
| cfg_ws_invert | input | 1 | Word-select polarity |
| cfg_size_code | input | 3 | Container size code |
| cfg_pad_bits | input | 3 | Container bits beyond the sample |
| cfg_slot_len_m1 | input | LEN_W | Slot length minus one |
| cfg_data_delay | input | LEN_W | Bit clocks before the first container bit |
| cfg_pulse_len_m1 | input | SYNC_W | Pulse width minus one |
| cfg_slots_m1 | input | SLOT_W | Slots per frame minus one |
| cfg_slot_mask | input | MAX_SLOTS | Per-slot enable |
| cfg_lsb_first | input | 1 | Bit order |
| cfg_fall_drive | input | 1 | Drive on falling edge |
| cfg_hiz_mode | input | 2 | Output-enable policy |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Sample taken this clock if valid |
| s_data | input | SAMPLE_W | Right-justified sample |
| uf_clear | input | 1 | Clears the underflow flag |
| frame_sync | output | 1 | Word select or frame pulse |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Serial data drive enable |
| underflow | output | 1 | Sticky missed-sample flag |

## Verification
If the slot or frame counters go wrong, `frame_sync` or `s_ready` departs from the expected pattern within one slot, and no later than the next frame boundary. If the held sample word or the bit pick goes wrong, `sdata` differs in the first bit clock that carries the faulty bit. If the edge retiming or enable stage goes wrong, it shows within half a bit clock, because the outputs are compared in both clock phases. A lost or spurious miss shows on `underflow` in the clock after the slot start.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

    typedef enum logic [1:0] {
        HIZ_NEVER = 2'd0,
        HIZ_GAPS  = 2'd1,
        HIZ_HALF  = 2'd2,
        HIZ_ALT   = 2'd3
    } hiz_mode_e;

    // container width in bits for a size code (code 0 treated as 8)
    function automatic logic [5:0] container_bits(input logic [2:0] code);
        if (code == 3'd0) return 6'd8;
        return {1'b0, code, 2'b00} + 6'd4;
    endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
    parameter int LEN_W  = 11,
    parameter int SLOT_W = 3,
    localparam int POS_W = LEN_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [SLOT_W-1:0] slots_m1,
    output logic [LEN_W-1:0]  bit_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [POS_W-1:0]  frame_pos
);

    typedef struct packed {
        logic [LEN_W-1:0]  bit_c;
        logic [SLOT_W-1:0] slot_c;
        logic [POS_W-1:0]  pos;
    } tstate_t;

    tstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.bit_c == len_m1) begin
            st_d.bit_c = '0;
            if (st_q.slot_c == slots_m1) begin
                st_d.slot_c = '0;
                st_d.pos    = '0;
            end else begin
                st_d.slot_c = st_q.slot_c + 1'b1;
                st_d.pos    = st_q.pos + 1'b1;
            end
        end else begin
            st_d.bit_c = st_q.bit_c + 1'b1;
            st_d.pos   = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_idx   = st_q.bit_c;
    assign slot_idx  = st_q.slot_c;
    assign frame_pos = st_q.pos;

    // R1: slot counter never runs past the configured slot length
    p_bit_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bit_c <= len_m1);

    // R1: the last bit of the last slot is followed by frame position 0
    p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bit_c == len_m1 && st_q.slot_c == slots_m1)
        |=> (st_q.pos == '0 && st_q.bit_c == '0 && st_q.slot_c == '0));

endmodule

// File: rtl/tdm_bit_engine.sv
module tdm_bit_engine
    import tdm_ser_pkg::*;
#(
    parameter int SAMPLE_W  = 32,
    parameter int LEN_W     = 11,
    parameter int SYNC_W    = 8,
    parameter int SLOT_W    = 3,
    localparam int MAX_SLOTS = 1 << SLOT_W,
    localparam int POS_W     = LEN_W + SLOT_W,
    localparam int IDX_W     = $clog2(SAMPLE_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pulse_mode,
    input  logic                 ws_invert,
    input  logic [2:0]           size_code,
    input  logic [2:0]           pad_bits,
    input  logic [LEN_W-1:0]     data_delay,
    input  logic [SYNC_W-1:0]    pulse_len_m1,
    input  logic [SLOT_W-1:0]    slots_m1,
    input  logic [MAX_SLOTS-1:0] slot_mask,
    input  logic                 lsb_first,
    input  logic [LEN_W-1:0]     bit_idx,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic [POS_W-1:0]     frame_pos,
    input  logic                 s_valid,
    input  logic [SAMPLE_W-1:0]  s_data,
    input  logic                 uf_clear,
    output logic                 s_ready,
    output logic                 sync_p,
    output logic                 sd_p,
    output logic                 act_p,
    output logic                 underflow
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] word;
        logic                sync;
        logic                sd;
        logic                act;
        logic                uf;
    } bstate_t;

    bstate_t st_d, st_q;

    logic             slot_on, slot_start, take, miss;
    logic [5:0]       cont, vbits;
    logic [LEN_W-1:0] rel;
    logic             in_cont, in_data;
    logic [IDX_W-1:0] pick;
    logic [SLOT_W:0]  half;
    logic             ws_raw;

    assign slot_on    = slot_mask[slot_idx];
    assign slot_start = (bit_idx == '0);
    assign s_ready    = slot_on && slot_start;

    always_comb begin
        st_d = st_q;
        take = s_ready && s_valid;
        miss = s_ready && !s_valid;

        if (take)            st_d.word = s_data;
        else if (slot_start) st_d.word = '0;

        cont    = container_bits(size_code);
        vbits   = cont - {3'b000, pad_bits};
        rel     = bit_idx - data_delay;
        in_cont = (bit_idx >= data_delay) && (rel < LEN_W'(cont));
        in_data = in_cont && (rel < LEN_W'(vbits));
        pick    = lsb_first ? rel[IDX_W-1:0]
                            : (vbits[IDX_W-1:0] - IDX_W'(1) - rel[IDX_W-1:0]);

        st_d.act = slot_on && in_cont;
        st_d.sd  = slot_on && in_data && st_d.word[pick];

        half   = ({1'b0, slots_m1} + (SLOT_W+1)'(2)) >> 1;
        ws_raw = ({1'b0, slot_idx} >= half);
        if (pulse_mode) st_d.sync = (frame_pos <= POS_W'(pulse_len_m1));
        else            st_d.sync = ws_raw ^ ws_invert;

        st_d.uf = miss || (st_q.uf && !uf_clear);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_p    = st_q.sync;
    assign sd_p      = st_q.sd;
    assign act_p     = st_q.act;
    assign underflow = st_q.uf;

    // R4: an accepted sample is the word held for the slot
    p_take_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && s_valid) |=> (st_q.word == $past(s_data)));

    // R10: a missed slot start raises the flag
    p_miss_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && !s_valid) |=> st_q.uf);

    // R10: the flag only falls on a clear
    p_uf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.uf && !uf_clear) |=> st_q.uf);

    // R5: a one on the line only inside an enabled container
    p_data_in_container_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sd |-> st_q.act);

endmodule

// File: rtl/tdm_edge_stage.sv
module tdm_edge_stage
    import tdm_ser_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fall_drive,
    input  logic [1:0] hiz_mode,
    input  logic       sync_p,
    input  logic       sd_p,
    input  logic       act_p,
    output logic       sync_o,
    output logic       sd_o,
    output logic       oe_o
);

    typedef struct packed {
        logic sync;
        logic sd;
        logic act;
    } nstate_t;

    nstate_t n_d, n_q;
    logic    late_d, late_q;
    logic    act_sel, act_tail;

    always_comb begin
        n_d    = '{sync: sync_p, sd: sd_p, act: act_p};
        late_d = n_q.act;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) late_q <= 1'b0;
        else        late_q <= late_d;
    end

    always_comb begin
        sync_o   = fall_drive ? n_q.sync : sync_p;
        sd_o     = fall_drive ? n_q.sd   : sd_p;
        act_sel  = fall_drive ? n_q.act  : act_p;
        act_tail = fall_drive ? late_q   : n_q.act;
        case (hiz_mode_e'(hiz_mode))
            HIZ_GAPS: oe_o = act_sel;
            HIZ_HALF: oe_o = act_sel || act_tail;
            default:  oe_o = 1'b1;
        endcase
    end

    // R9: a data one is never sent while the line is released
    p_data_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sd_o |-> oe_o);

    // R9: with no hi-Z policy the line is always driven
    p_oe_never_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hiz_mode == 2'd0) |-> oe_o);

    // R8: falling-edge outputs, seen at the rising edge, match the value launched half a clock earlier
    p_fall_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_drive |-> (sd_o == sd_p && sync_o == sync_p));

endmodule

// File: rtl/tdm_frame_serializer.sv
module tdm_frame_serializer
    import tdm_ser_pkg::*;
#(
    parameter int SAMPLE_W  = 32,
    parameter int LEN_W     = 11,
    parameter int SYNC_W    = 8,
    parameter int MAX_SLOTS = 8,
    localparam int SLOT_W   = $clog2(MAX_SLOTS),
    localparam int POS_W    = LEN_W + SLOT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_pulse_mode,
    input  logic                 cfg_ws_invert,
    input  logic [2:0]           cfg_size_code,
    input  logic [2:0]           cfg_pad_bits,
    input  logic [LEN_W-1:0]     cfg_slot_len_m1,
    input  logic [LEN_W-1:0]     cfg_data_delay,
    input  logic [SYNC_W-1:0]    cfg_pulse_len_m1,
    input  logic [SLOT_W-1:0]    cfg_slots_m1,
    input  logic [MAX_SLOTS-1:0] cfg_slot_mask,
    input  logic                 cfg_lsb_first,
    input  logic                 cfg_fall_drive,
    input  logic [1:0]           cfg_hiz_mode,
    input  logic                 s_valid,
    output logic                 s_ready,
    input  logic [SAMPLE_W-1:0]  s_data,
    input  logic                 uf_clear,
    output logic                 frame_sync,
    output logic                 sdata,
    output logic                 sdata_oe,
    output logic                 underflow
);

    logic [LEN_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] slot_idx;
    logic [POS_W-1:0]  frame_pos;
    logic              sync_p, sd_p, act_p;

    tdm_slot_timer #(.LEN_W(LEN_W), .SLOT_W(SLOT_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_m1    (cfg_slot_len_m1),
        .slots_m1  (cfg_slots_m1),
        .bit_idx   (bit_idx),
        .slot_idx  (slot_idx),
        .frame_pos (frame_pos)
    );

    tdm_bit_engine #(
        .SAMPLE_W (SAMPLE_W),
        .LEN_W    (LEN_W),
        .SYNC_W   (SYNC_W),
        .SLOT_W   (SLOT_W)
    ) engine_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pulse_mode   (cfg_pulse_mode),
        .ws_invert    (cfg_ws_invert),
        .size_code    (cfg_size_code),
        .pad_bits     (cfg_pad_bits),
        .data_delay   (cfg_data_delay),
        .pulse_len_m1 (cfg_pulse_len_m1),
        .slots_m1     (cfg_slots_m1),
        .slot_mask    (cfg_slot_mask),
        .lsb_first    (cfg_lsb_first),
        .bit_idx      (bit_idx),
        .slot_idx     (slot_idx),
        .frame_pos    (frame_pos),
        .s_valid      (s_valid),
        .s_data       (s_data),
        .uf_clear     (uf_clear),
        .s_ready      (s_ready),
        .sync_p       (sync_p),
        .sd_p         (sd_p),
        .act_p        (act_p),
        .underflow    (underflow)
    );

    tdm_edge_stage edge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_drive (cfg_fall_drive),
        .hiz_mode   (cfg_hiz_mode),
        .sync_p     (sync_p),
        .sd_p       (sd_p),
        .act_p      (act_p),
        .sync_o     (frame_sync),
        .sd_o       (sdata),
        .oe_o       (sdata_oe)
    );

endmodule

// File: tb/tdm_frame_serializer_tb_top.sv
module tdm_frame_serializer_tb_top;

    localparam int CLK_T = 8;
    localparam int QTR   = CLK_T / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pm = 0, inv = 0, lsb = 0, fall = 0;
    logic [2:0]  sc = 3'd3, pad = 3'd0, sm1 = 3'd1;
    logic [10:0] lm1 = 11'd15, off = 11'd0;
    logic [7:0]  pw = 8'd0, msk = 8'h03;
    logic [1:0]  hz = 2'd0;
    logic        s_valid = 0, uf_clear = 0;
    logic [31:0] s_data = 32'h0;
    logic        s_ready, frame_sync, sdata, sdata_oe, underflow;

    int vectors = 0, misses = 0, cyc = 0;
    bit done = 0;

    always #(CLK_T/2) clk = ~clk;

    tdm_frame_serializer dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_pulse_mode(pm), .cfg_ws_invert(inv), .cfg_size_code(sc),
        .cfg_pad_bits(pad), .cfg_slot_len_m1(lm1), .cfg_data_delay(off),
        .cfg_pulse_len_m1(pw), .cfg_slots_m1(sm1), .cfg_slot_mask(msk),
        .cfg_lsb_first(lsb), .cfg_fall_drive(fall), .cfg_hiz_mode(hz),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .uf_clear(uf_clear), .frame_sync(frame_sync), .sdata(sdata),
        .sdata_oe(sdata_oe), .underflow(underflow)
    );

    // behavioural reference: position counter, current slot word, flag
    int          pos = 0;
    logic [31:0] m_word = 0;
    logic        m_uf = 0;
    logic        c_sync = 0, c_sd = 0, c_act = 0;
    logic        p_sync = 0, p_sd = 0, p_act = 0;

    function automatic int frame_len();
        return (int'(lm1) + 1) * (int'(sm1) + 1);
    endfunction

    function automatic logic exp_ready();
        int fp, sl, b;
        fp = pos % frame_len();
        sl = fp / (int'(lm1) + 1);
        b  = fp % (int'(lm1) + 1);
        return (b == 0) && msk[sl];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pos = 0; m_word = 0; m_uf = 0;
            c_sync = 0; c_sd = 0; c_act = 0;
            p_sync = 0; p_sd = 0; p_act = 0;
        end else begin
            int fp, sl, b, cont, vb, r, ns;
            logic on, miss;
            p_sync = c_sync; p_sd = c_sd; p_act = c_act;
            ns = int'(sm1) + 1;
            fp = pos % frame_len();
            sl = fp / (int'(lm1) + 1);
            b  = fp % (int'(lm1) + 1);
            on = msk[sl];
            miss = 0;
            if (b == 0) begin
                if (on && s_valid) m_word = s_data;
                else m_word = 0;
                miss = on && !s_valid;
            end
            cont = (sc == 0) ? 8 : 4 * int'(sc) + 4;
            vb = cont - int'(pad);
            r = b - int'(off);
            c_act = on && (b >= int'(off)) && (r < cont);
            c_sd = c_act && (r < vb) && (lsb ? m_word[r] : m_word[vb-1-r]);
            if (pm) c_sync = (fp <= int'(pw));
            else    c_sync = (sl >= (ns + 1) / 2) ^ inv;
            m_uf = miss || (m_uf && !uf_clear);
            pos++;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
        end
    endtask

    function automatic logic oe_high_phase();
        if (hz == 2'd1) return fall ? p_act : c_act;
        if (hz == 2'd2) return fall ? p_act : (c_act | p_act);
        return 1'b1;
    endfunction

    function automatic logic oe_low_phase();
        if (hz == 2'd1) return c_act;
        if (hz == 2'd2) return fall ? (c_act | p_act) : c_act;
        return 1'b1;
    endfunction

    task automatic run(input logic i_pm, input logic i_inv, input logic [2:0] i_sc,
                       input logic [2:0] i_pad, input int i_lm1, input int i_off,
                       input int i_pw, input int i_sm1, input logic [7:0] i_msk,
                       input logic i_lsb, input logic i_fall, input logic [1:0] i_hz,
                       input int gap, input int ncyc);
        string stag;
        @(negedge clk);
        rst_n = 0;
        pm = i_pm; inv = i_inv; sc = i_sc; pad = i_pad;
        lm1 = 11'(i_lm1); off = 11'(i_off); pw = 8'(i_pw); sm1 = 3'(i_sm1);
        msk = i_msk; lsb = i_lsb; fall = i_fall; hz = i_hz;
        s_valid = 0; uf_clear = 0;
        repeat (2) @(negedge clk);
        #QTR;
        // R11: reset values
        chk("R11 sync", frame_sync, 1'b0);
        chk("R11 sdata", sdata, 1'b0);
        chk("R11 underflow", underflow, 1'b0);
        chk("R11 oe", sdata_oe, (hz == 2'd0 || hz == 2'd3));
        @(negedge clk);
        rst_n = 1;
        s_valid = 1; s_data = 32'hA5C3_1E69;
        stag = pm ? "R3 sync" : "R2 sync";
        for (int k = 0; k < ncyc && !done; k++) begin
            @(posedge clk);
            #QTR;
            chk(stag, frame_sync, fall ? p_sync : c_sync);
            chk("R5 R6 R7 R8 sdata high phase", sdata, fall ? p_sd : c_sd);
            chk("R9 oe high phase", sdata_oe, oe_high_phase());
            chk("R10 underflow", underflow, m_uf);
            chk("R1 R4 ready", s_ready, exp_ready());
            @(negedge clk);
            s_valid = (gap == 0) || ((k % gap) != 0);
            s_data = s_data * 32'd1103515245 + 32'd12345;
            uf_clear = ((k % 53) == 52);
            #QTR;
            chk(stag, frame_sync, c_sync);
            chk("R5 R6 R7 R8 sdata low phase", sdata, c_sd);
            chk("R9 oe low phase", sdata_oe, oe_low_phase());
        end
    endtask

    initial begin
        // word select, 2x16, 16-bit containers, always valid
        run(0, 0, 3'd3, 3'd0, 15, 0, 0, 1, 8'h03, 0, 0, 2'd0, 0, 300);
        // inverted word select, 12-bit container with 2 pad bits, delay 1, LSB first, falling edge
        run(0, 1, 3'd2, 3'd2, 19, 1, 0, 1, 8'h03, 1, 1, 2'd1, 3, 300);
        // pulse framing, 8 slots of 8, sparse mask, 1-clock pulse, half-clock hold
        run(1, 0, 3'd1, 3'd3, 7, 0, 0, 7, 8'hA5, 0, 0, 2'd2, 5, 400);
        // pulse framing, 32-bit containers filling the slot, falling edge, half-clock hold
        run(1, 0, 3'd7, 3'd0, 33, 2, 5, 3, 8'h0E, 1, 1, 2'd2, 4, 500);
        // code 0, container cut at slot end, pulse longer than frame
        run(1, 0, 3'd0, 3'd1, 9, 3, 40, 2, 8'h07, 0, 0, 2'd1, 2, 300);
        // single slot word select, 24-bit containers, mode 3 drives always
        run(0, 0, 3'd5, 3'd0, 23, 0, 0, 0, 8'h01, 0, 1, 2'd3, 7, 300);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            done = 1;
            misses++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule